// File: doc/BRIEF.md
# Sequential Packed-Result Divider

This block is a multi-cycle integer divider. It takes a dividend and a divisor and returns the quotient and the remainder packed together into one word. That word is as wide as the dividend. Two operand sizes are selectable per operation. In half size, a 16-bit dividend is divided by an 8-bit divisor. In full size, a 32-bit dividend is divided by a 16-bit divisor. Each size can run unsigned or as two's-complement signed.

A pulse on `start_i` while the unit is idle captures the operands. A shift-subtract core then resolves one quotient bit per cycle, followed by one sign-correction and packing cycle. Completion is a single-cycle `done_o` pulse. The packed result, a negative flag and a zero flag are held until the next completion. A zero divisor needs no iterations: it finishes on the cycle after acceptance and hands the dividend back unchanged.

Top module: `sdiv_packed`

## Requirements
- R1: In half size (`wide_i`=0), only `dividend_i[15:0]` and `divisor_i[7:0]` are used. `result_o[7:0]` is the quotient, `result_o[15:8]` is the remainder, and `result_o[31:16]` is zero.
- R2: In full size (`wide_i`=1), `result_o[15:0]` is the quotient and `result_o[31:16]` is the remainder of `dividend_i` divided by `divisor_i`.
- R3: In unsigned mode (`signed_i`=0) with a nonzero divisor, `neg_o` equals the top bit of the divisor at the selected size (bit 7 or bit 15), and `zero_o` is 0.
- R4: In signed mode, both operands are sign-extended from their selected size. The quotient truncates toward zero and the remainder takes the sign of the dividend.
- R5: In signed mode with a nonzero divisor, `neg_o` equals the top bit of the quotient taken at the dividend width (bit 15 in half size, bit 31 in full size), and `zero_o` is 0.
- R6: A divisor that is zero at the selected size completes on the first cycle after acceptance. `done_o` is 1, `zero_o` is 1 and `neg_o` is 0. `result_o` is `dividend_i` in full size, or `dividend_i[15:0]` zero-extended in half size.
- R7: With a nonzero divisor, `done_o` rises 17 clock edges after the accepting edge in half size and 33 in full size. `busy_o` is high from the accepting edge until completion.
- R8: `done_o` is high for exactly one cycle per operation. `result_o`, `neg_o` and `zero_o` hold their values until the next completion.
- R9: `start_i` is ignored while `busy_o` is high. It neither restarts nor queues an operation.
- R10: When the true quotient does not fit its packed field, the quotient and remainder fields keep only their low bits.
- R11: After reset, `busy_o`, `done_o`, `neg_o`, `zero_o` and `result_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a division; taken only when idle |
| wide_i | input | 1 | 0: 16/8 size, 1: 32/16 size |
| signed_i | input | 1 | 1: two's-complement operands |
| dividend_i | input | 32 | Dividend; low 16 bits in half size |
| divisor_i | input | 16 | Divisor; low 8 bits in half size |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 32 | Packed remainder (high) and quotient (low) |
| neg_o | output | 1 | Negative flag |
| zero_o | output | 1 | Zero flag (zero divisor) |

## Verification
The hardest situation to reach from the ports is a new request arriving mid-operation. The risk is that the new request silently overwrites captured mode bits or operands. A zero-divisor request is the most damaging case, because if accepted it would complete at once. The stimulus starts a full-size division and, a few cycles later, pulses `start_i` with a half-size zero-divisor request. It then checks that the original result, flags and 33-edge latency survive and that no second completion follows. Signed quotient overflow (the most negative dividend divided by minus one) is driven directly from the vector table.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } div_state_e;

  typedef struct packed {
    logic wide;
    logic sgn;
    logic neg_q;
    logic neg_r;
    logic dvs_msb;
  } div_op_t;
endpackage

// File: rtl/sdiv_prep.sv
// Operand conditioning: size select, sign extension, magnitudes, result signs.
module sdiv_prep #(
  parameter int DVD_W = 32,
  parameter int DVS_W = 16
) (
  input  logic             wide_i,
  input  logic             signed_i,
  input  logic [DVD_W-1:0] dividend_i,
  input  logic [DVS_W-1:0] divisor_i,
  output logic [DVD_W-1:0] dvd_mag_o,
  output logic [DVS_W-1:0] dvs_mag_o,
  output logic             neg_q_o,
  output logic             neg_r_o,
  output logic             dvs_zero_o,
  output logic             dvs_msb_o
);
  localparam int HD = DVD_W / 2;
  localparam int HS = DVS_W / 2;

  logic             dd_sign, ds_sign;
  logic             dd_neg, ds_neg;
  logic [DVD_W-1:0] dd_ext, dd_mag;
  logic [DVS_W-1:0] ds_ext;

  always_comb begin
    dd_sign = wide_i ? dividend_i[DVD_W-1] : dividend_i[HD-1];
    ds_sign = wide_i ? divisor_i[DVS_W-1]  : divisor_i[HS-1];
    dd_neg  = signed_i & dd_sign;
    ds_neg  = signed_i & ds_sign;
    dd_ext  = wide_i ? dividend_i : {{HD{dd_neg}}, dividend_i[HD-1:0]};
    ds_ext  = wide_i ? divisor_i  : {{HS{ds_neg}}, divisor_i[HS-1:0]};
    dd_mag  = dd_neg ? -dd_ext : dd_ext;
    // half size is left-aligned so the core shifts the same register in both sizes
    dvd_mag_o  = wide_i ? dd_mag : {dd_mag[HD-1:0], {HD{1'b0}}};
    dvs_mag_o  = ds_neg ? -ds_ext : ds_ext;
    neg_q_o    = dd_neg ^ ds_neg;
    neg_r_o    = dd_neg;
    dvs_zero_o = wide_i ? (divisor_i == '0) : (divisor_i[HS-1:0] == '0);
    dvs_msb_o  = ds_sign;
  end
endmodule

// File: rtl/sdiv_core.sv
// Restoring shift-subtract core, one quotient bit per step.
module sdiv_core #(
  parameter int DVD_W = 32,
  parameter int DVS_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [DVD_W-1:0] dvd_i,
  input  logic [DVS_W-1:0] dvs_i,
  output logic [DVD_W-1:0] quo_o,
  output logic [DVS_W-1:0] rem_o
);
  logic [DVD_W-1:0] q_q;
  logic [DVS_W-1:0] r_q, d_q;
  logic [DVS_W:0]   part, diff;
  logic             take;

  always_comb begin
    part = {r_q, q_q[DVD_W-1]};
    diff = part - {1'b0, d_q};
    take = (part >= {1'b0, d_q});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q <= '0;
      r_q <= '0;
      d_q <= '0;
    end else if (load_i) begin
      q_q <= dvd_i;
      r_q <= '0;
      d_q <= dvs_i;
    end else if (step_i) begin
      r_q <= take ? diff[DVS_W-1:0] : part[DVS_W-1:0];
      q_q <= {q_q[DVD_W-2:0], take};
    end
  end

  assign quo_o = q_q;
  assign rem_o = r_q;
endmodule

// File: rtl/sdiv_pack.sv
// Sign correction, field truncation and flag selection.
module sdiv_pack #(
  parameter int DVD_W = 32,
  parameter int DVS_W = 16
) (
  input  logic             wide_i,
  input  logic             sgn_i,
  input  logic             neg_q_i,
  input  logic             neg_r_i,
  input  logic             dvs_msb_i,
  input  logic [DVD_W-1:0] quo_i,
  input  logic [DVS_W-1:0] rem_i,
  output logic [DVD_W-1:0] result_o,
  output logic             neg_o
);
  localparam int HD = DVD_W / 2;
  localparam int HS = DVS_W / 2;

  logic [DVD_W-1:0] quo_s;
  logic [DVS_W-1:0] rem_s;

  always_comb begin
    quo_s = neg_q_i ? -quo_i : quo_i;
    rem_s = neg_r_i ? -rem_i : rem_i;
    if (wide_i) begin
      result_o = {rem_s, quo_s[DVS_W-1:0]};
      neg_o    = sgn_i ? quo_s[DVD_W-1] : dvs_msb_i;
    end else begin
      result_o = {{(DVD_W-2*HS){1'b0}}, rem_s[HS-1:0], quo_s[HS-1:0]};
      neg_o    = sgn_i ? quo_s[HD-1] : dvs_msb_i;
    end
  end
endmodule

// File: rtl/sdiv_packed.sv
module sdiv_packed #(
  parameter int DVD_W = 32,
  parameter int DVS_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             wide_i,
  input  logic             signed_i,
  input  logic [DVD_W-1:0] dividend_i,
  input  logic [DVS_W-1:0] divisor_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [DVD_W-1:0] result_o,
  output logic             neg_o,
  output logic             zero_o
);
  import sdiv_pkg::*;

  localparam int HD    = DVD_W / 2;
  localparam int CNT_W = $clog2(DVD_W + 1);

  div_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  div_op_t          op_q;
  logic [DVD_W-1:0] result_q;
  logic             neg_q, zero_q, done_q;

  logic [DVD_W-1:0] dvd_mag, quo, pack_res;
  logic [DVS_W-1:0] dvs_mag, rem;
  logic             p_neg_q, p_neg_r, p_zero, p_msb, pack_neg;
  logic             accept, load;

  sdiv_prep #(.DVD_W(DVD_W), .DVS_W(DVS_W)) u_prep (
    .wide_i     (wide_i),
    .signed_i   (signed_i),
    .dividend_i (dividend_i),
    .divisor_i  (divisor_i),
    .dvd_mag_o  (dvd_mag),
    .dvs_mag_o  (dvs_mag),
    .neg_q_o    (p_neg_q),
    .neg_r_o    (p_neg_r),
    .dvs_zero_o (p_zero),
    .dvs_msb_o  (p_msb)
  );

  assign accept = (state_q == ST_IDLE) && start_i;
  assign load   = accept && !p_zero;

  sdiv_core #(.DVD_W(DVD_W), .DVS_W(DVS_W)) u_core (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .step_i (state_q == ST_RUN),
    .dvd_i  (dvd_mag),
    .dvs_i  (dvs_mag),
    .quo_o  (quo),
    .rem_o  (rem)
  );

  sdiv_pack #(.DVD_W(DVD_W), .DVS_W(DVS_W)) u_pack (
    .wide_i    (op_q.wide),
    .sgn_i     (op_q.sgn),
    .neg_q_i   (op_q.neg_q),
    .neg_r_i   (op_q.neg_r),
    .dvs_msb_i (op_q.dvs_msb),
    .quo_i     (quo),
    .rem_i     (rem),
    .result_o  (pack_res),
    .neg_o     (pack_neg)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      op_q     <= '0;
      result_q <= '0;
      neg_q    <= 1'b0;
      zero_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            op_q <= '{wide: wide_i, sgn: signed_i, neg_q: p_neg_q,
                      neg_r: p_neg_r, dvs_msb: p_msb};
            if (p_zero) begin
              result_q <= wide_i ? dividend_i : {{HD{1'b0}}, dividend_i[HD-1:0]};
              neg_q    <= 1'b0;
              zero_q   <= 1'b1;
              done_q   <= 1'b1;
            end else begin
              cnt_q   <= wide_i ? CNT_W'(DVD_W) : CNT_W'(HD);
              state_q <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == CNT_W'(1)) state_q <= ST_FIX;
        end
        ST_FIX: begin
          result_q <= pack_res;
          neg_q    <= pack_neg;
          zero_q   <= 1'b0;
          done_q   <= 1'b1;
          state_q  <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_q;
  assign result_o = result_q;
  assign neg_o    = neg_q;
  assign zero_o   = zero_q;
endmodule

// File: rtl/sdiv_packed_chk.sv
module sdiv_packed_chk #(
  parameter int DVD_W = 32,
  parameter int DVS_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             wide_i,
  input logic [DVS_W-1:0] divisor_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [DVD_W-1:0] result_o,
  input logic             neg_o,
  input logic             zero_o
);
  localparam int HS = DVS_W / 2;
  logic zero_div;
  assign zero_div = wide_i ? (divisor_i == '0) : (divisor_i[HS-1:0] == '0);

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o)); // R8
  AST_ZERO_DIV_FAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && zero_div) |=> (done_o && zero_o && !neg_o)); // R6
  AST_BUSY_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && !zero_div) |=> (busy_o && !done_o)); // R7
  AST_BUSY_ENDS_IN_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (busy_o || done_o)); // R7
  AST_NO_DONE_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !done_o); // R9
endmodule

bind sdiv_packed sdiv_packed_chk #(.DVD_W(DVD_W), .DVS_W(DVS_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .wide_i    (wide_i),
  .divisor_i (divisor_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .result_o  (result_o),
  .neg_o     (neg_o),
  .zero_o    (zero_o)
);

// File: tb/sdiv_packed_bench.sv
`timescale 1ns/1ps
module sdiv_packed_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, wide = 1'b0, sgn = 1'b0;
  logic [31:0] dvd = '0;
  logic [15:0] dvs = '0;
  logic        busy, done, neg, zero;
  logic [31:0] result;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  sdiv_packed u_sdiv_packed (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .wide_i(wide), .signed_i(sgn),
    .dividend_i(dvd), .divisor_i(dvs), .busy_o(busy), .done_o(done),
    .result_o(result), .neg_o(neg), .zero_o(zero)
  );

  // {wide, signed, dividend, divisor}
  localparam int NV = 14;
  localparam bit [49:0] VEC [NV] = '{
    {1'b0, 1'b0, 32'h0000_0064, 16'h0007},
    {1'b0, 1'b0, 32'h0000_FFFF, 16'h0001},
    {1'b0, 1'b0, 32'h0000_00FF, 16'hAB80},
    {1'b0, 1'b1, 32'hABCD_FF9C, 16'h0007},
    {1'b0, 1'b1, 32'h0000_0064, 16'h00F9},
    {1'b0, 1'b1, 32'h0000_8000, 16'h00FF},
    {1'b0, 1'b1, 32'h0000_0003, 16'h00F9},
    {1'b1, 1'b0, 32'h000F_4240, 16'h03E8},
    {1'b1, 1'b0, 32'hFFFF_FFFF, 16'hFFFF},
    {1'b1, 1'b0, 32'h1234_5678, 16'h8001},
    {1'b1, 1'b1, 32'hFFF0_BDC0, 16'h03E8},
    {1'b1, 1'b1, 32'h0000_0007, 16'hFFFE},
    {1'b1, 1'b1, 32'hFFFF_FFF9, 16'h0002},
    {1'b1, 1'b1, 32'h8000_0000, 16'hFFFF}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic void model(input bit w, input bit s, input logic [31:0] dd,
                                input logic [15:0] ds, output logic [31:0] r,
                                output bit n, output bit z);
    longint a, b, q, m;
    if (w) begin
      a = s ? longint'($signed(dd)) : longint'(dd);
      b = s ? longint'($signed(ds)) : longint'(ds);
    end else begin
      a = s ? longint'($signed(dd[15:0])) : longint'(dd[15:0]);
      b = s ? longint'($signed(ds[7:0])) : longint'(ds[7:0]);
    end
    if (b == 0) begin
      r = w ? dd : {16'h0, dd[15:0]};
      n = 1'b0;
      z = 1'b1;
    end else begin
      q = a / b;
      m = a % b;
      z = 1'b0;
      if (w) begin
        r = {m[15:0], q[15:0]};
        n = s ? q[31] : ds[15];
      end else begin
        r = {16'h0, m[7:0], q[7:0]};
        n = s ? q[15] : ds[7];
      end
    end
  endfunction

  task automatic run_op(input bit w, input bit s, input logic [31:0] dd,
                        input logic [15:0] ds, input string rq, input string fq);
    logic [31:0] er;
    bit en, ez;
    int cyc, lat;
    model(w, s, dd, ds, er, en, ez);
    @(negedge clk);
    wide = w; sgn = s; dvd = dd; dvs = ds; start = 1'b1;
    cyc = 0;
    do begin
      @(posedge clk); @(negedge clk);
      start = 1'b0;
      cyc++;
    end while (!done && cyc < 100);
    lat = ez ? 1 : (w ? 34 : 18);
    check(cyc == lat, ez ? "R6" : "R7", "latency", cyc, lat);
    check(result == er, rq, "result", result, er);
    check({neg, zero} == {en, ez}, fq, "flags", {30'h0, neg, zero}, {30'h0, en, ez});
    @(negedge clk);
    check(!done, "R8", "done pulse width", done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] held;
    int cyc;
    bit extra;
    repeat (3) @(negedge clk);
    check({busy, done, neg, zero} == 4'b0 && result == 0, "R11", "in reset",
          {busy, done, neg, zero}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({busy, done, neg, zero} == 4'b0 && result == 0, "R11", "after reset",
          result, 0);

    for (int i = 0; i < NV; i++) begin
      run_op(VEC[i][49], VEC[i][48], VEC[i][47:16], VEC[i][15:0],
             VEC[i][48] ? "R4" : (VEC[i][49] ? "R2" : "R1"),
             VEC[i][48] ? "R5" : "R3");
    end

    // R10: 0xFFFF/1 unsigned half size keeps only low quotient byte
    run_op(1'b0, 1'b0, 32'h0000_FFFF, 16'h0001, "R10", "R3");
    check(result == 32'h0000_00FF, "R10", "truncated quotient", result, 32'h0000_00FF);
    // R10: signed -32768 / -1 half size: quotient 0x8000 -> field 0x00, N=1
    run_op(1'b0, 1'b1, 32'h0000_8000, 16'h00FF, "R10", "R5");
    check(result == 32'h0 && neg, "R10", "signed overflow", {result[30:0], neg}, 1);

    // R6: zero divisor, both sizes, including nonzero upper byte in half size
    run_op(1'b0, 1'b0, 32'hDEAD_1234, 16'h0100, "R6", "R6");
    check(result == 32'h0000_1234, "R6", "half pass-through", result, 32'h0000_1234);
    run_op(1'b1, 1'b1, 32'h8765_4321, 16'h0000, "R6", "R6");
    check(result == 32'h8765_4321, "R6", "full pass-through", result, 32'h8765_4321);

    // R8: outputs held with inputs changing and no start
    held = result;
    @(negedge clk);
    dvd = 32'h1111_1111; dvs = 16'h0003; wide = 1'b0;
    repeat (5) @(negedge clk);
    check(result == held && zero, "R8", "held result", result, held);

    // R9: zero-divisor request while busy must be ignored
    @(negedge clk);
    wide = 1'b1; sgn = 1'b0; dvd = 32'h000F_4240; dvs = 16'h03E8; start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    cyc = 1;
    repeat (4) begin @(posedge clk); @(negedge clk); cyc++; end
    check(busy, "R9", "busy mid-op", busy, 1);
    wide = 1'b0; sgn = 1'b1; dvd = 32'h0000_5555; dvs = 16'h0000; start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    cyc++;
    check(!done, "R9", "no early done", done, 0);
    while (!done && cyc < 100) begin @(posedge clk); @(negedge clk); cyc++; end
    check(cyc == 34, "R9", "latency unchanged", cyc, 34);
    check(result == 32'h0000_03E8 && !zero, "R9", "original result", result, 32'h0000_03E8);
    extra = 1'b0;
    repeat (4) begin @(negedge clk); if (done || busy) extra = 1'b1; end
    check(!extra, "R9", "no queued op", extra, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule